// File: doc/BRIEF.md
# Chip-Select Output Line Unit

This block drives a bank of chip-select / general-purpose output lines next to an SPI engine. Each line either holds a level that software forces or tracks the engine's frame-active signal as a chip select. Each line can also be inverted at the output, so that a device whose select is active-high can sit on the same bank.

Software controls the lines through two write ports. The force word carries one pair of bits per line, a raise bit and a lower bit, so that any mix of lines can be raised, lowered or left alone in one write. The mode word carries one pair per line as well: a hardware-select bit and an invert bit. The line outputs come straight from flops.

Top module: `spi_cs_lines`

## Requirements
- R1: While reset is asserted, and after it until the first write, every line output is 1: all forced levels are high, hardware-select mode is off and inversion is off.
- R2: A force write with bit n set and bit N+n clear (N = number of lines, 8 by default) sets the forced level of line n to 0.
- R3: A force write with bit N+n set and bit n clear sets the forced level of line n to 1.
- R4: A force write with both bit n and bit N+n set, or with neither set, leaves the forced level of line n unchanged.
- R5: When mode-word bit N+n is 1, line n is 0 (before inversion) in the cycle after frame_active is 1, and 1 in the cycle after frame_active is 0.
- R6: When mode-word bit n is 1, line n is the complement of its selected level; inversion is applied after the choice between forced level and hardware select, in both modes.
- R7: The forced level of a line is kept while the line is in hardware-select mode and appears again on the output once that mode is turned off.
- R8: Each line's level depends only on its own bits of the force and mode words; writes touching one line do not change the others.
- R9: A force or mode write appears on the outputs at the second rising edge counted from the edge that takes the write; a change of frame_active appears at the first rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| force_we | input | 1 | Write strobe for the force word |
| force_word | input | 2*LINES | Raise bits in the upper half, lower bits in the lower half |
| mode_we | input | 1 | Write strobe for the mode word |
| mode_word | input | 2*LINES | Hardware-select bits in the upper half, invert bits in the lower half |
| frame_active | input | 1 | High while the SPI engine runs a frame |
| line_out | output | LINES | Registered line outputs |

## Verification
The bench aims at a force write carrying both bits of one pair, where a design that gave one bit priority would move the line instead of holding it. It checks that inversion also acts on forced lines and on an idle hardware select, which a design inverting only active chip selects would miss. It turns hardware-select mode off after the frame toggled to catch a design that overwrote the forced level with the chip-select state, and it samples one cycle early after writes to expose a missing or extra register stage.

// File: rtl/spi_cs_lines.sv
module spi_cs_lines #(
  parameter int LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               force_we,
  input  logic [2*LINES-1:0] force_word,
  input  logic               mode_we,
  input  logic [2*LINES-1:0] mode_word,
  input  logic               frame_active,
  output logic [LINES-1:0]   line_out
);

  logic [LINES-1:0] forced_lvl;
  logic [LINES-1:0] hw_sel;
  logic [LINES-1:0] invert;
  logic [LINES-1:0] next_out;

  wire [LINES-1:0] raise_bits = force_word[2*LINES-1:LINES];
  wire [LINES-1:0] lower_bits = force_word[LINES-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_sel <= '0;
      invert <= '0;
    end else if (mode_we) begin
      hw_sel <= mode_word[2*LINES-1:LINES];
      invert <= mode_word[LINES-1:0];
    end
  end

  genvar i;
  generate
    for (i = 0; i < LINES; i++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          forced_lvl[i] <= 1'b1;
        else if (force_we && (raise_bits[i] ^ lower_bits[i]))
          forced_lvl[i] <= raise_bits[i];
      end

      assign next_out[i] = (hw_sel[i] ? ~frame_active : forced_lvl[i]) ^ invert[i];

      a_r2_lower_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
        (force_we && lower_bits[i] && !raise_bits[i]) |=> !forced_lvl[i]);

      a_r3_raise_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
        (force_we && raise_bits[i] && !lower_bits[i]) |=> forced_lvl[i]);

      a_r4_pair_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (force_we && (raise_bits[i] == lower_bits[i])) |=> $stable(forced_lvl[i]));

      a_r5_select_tracks_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_sel[i] && !invert[i] && frame_active) |=> !line_out[i]);

      a_r6_invert_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_sel[i] && invert[i] && forced_lvl[i]) |=> !line_out[i]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      line_out <= '1;
    else
      line_out <= next_out;
  end

  a_r1_reset_high: assert property (@(posedge clk)
    !rst_n |=> (line_out == '1));

endmodule

// File: tb/tb_spi_cs_lines.sv
module tb_spi_cs_lines;
  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           force_we = 1'b0;
  logic [2*N-1:0] force_word = '0;
  logic           mode_we = 1'b0;
  logic [2*N-1:0] mode_word = '0;
  logic           frame_active = 1'b0;
  logic [N-1:0]   line_out;

  int checks = 0;
  int errors = 0;
  string phase = "R1";

  spi_cs_lines #(.LINES(N)) dut (
    .clk(clk), .rst_n(rst_n),
    .force_we(force_we), .force_word(force_word),
    .mode_we(mode_we), .mode_word(mode_word),
    .frame_active(frame_active), .line_out(line_out)
  );

  always #5 clk = ~clk;

  // behavioural reference: per-line integers, evaluated at each edge
  int m_lvl [N];
  int m_sel [N];
  int m_inv [N];
  logic [N-1:0] m_out;

  initial begin
    for (int k = 0; k < N; k++) begin m_lvl[k] = 1; m_sel[k] = 0; m_inv[k] = 0; end
    m_out = '1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) begin m_lvl[k] = 1; m_sel[k] = 0; m_inv[k] = 0; end
      m_out = '1;
    end else begin
      logic [N-1:0] o;
      for (int k = 0; k < N; k++) begin
        int v;
        v = m_sel[k] ? (frame_active ? 0 : 1) : m_lvl[k];
        if (m_inv[k] != 0) v = 1 - v;
        o[k] = (v != 0);
      end
      m_out = o;
      if (force_we)
        for (int k = 0; k < N; k++) begin
          if (force_word[N+k] && !force_word[k]) m_lvl[k] = 1;
          else if (force_word[k] && !force_word[N+k]) m_lvl[k] = 0;
        end
      if (mode_we)
        for (int k = 0; k < N; k++) begin
          m_sel[k] = mode_word[N+k];
          m_inv[k] = mode_word[k];
        end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (line_out !== m_out) begin
      errors++;
      $display("FAIL %s model compare: actual %h expected %h", phase, line_out, m_out);
    end
  end

  task automatic expect_out(input string req, input logic [N-1:0] exp);
    checks++;
    if (line_out !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, line_out, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic write_force(input logic [2*N-1:0] w);
    force_word = w; force_we = 1'b1;
    step();
    force_we = 1'b0; force_word = '0;
    step();
  endtask

  task automatic write_mode(input logic [2*N-1:0] w);
    mode_word = w; mode_we = 1'b1;
    step();
    mode_we = 1'b0; mode_word = '0;
    step();
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 5000) begin
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    expect_out("R1 during reset", 8'hFF);
    step(); step();
    rst_n = 1'b1;
    step();
    expect_out("R1 after reset", 8'hFF);

    phase = "R2";
    write_force(16'h0001);
    expect_out("R2 lower line0", 8'hFE);

    phase = "R3";
    write_force(16'h0100);
    expect_out("R3 raise line0", 8'hFF);
    phase = "R8";
    write_force(16'h00A5);
    expect_out("R8 mixed lines lowered", 8'h5A);

    phase = "R4";
    write_force(16'h0303);
    expect_out("R4 both bits hold", 8'h5A);
    write_force(16'h0000);
    expect_out("R4 no bits hold", 8'h5A);

    phase = "R9";
    force_word = 16'h0002; force_we = 1'b1;
    step();
    force_we = 1'b0; force_word = '0;
    expect_out("R9 force not yet visible", 8'h5A);
    step();
    expect_out("R9 force visible second edge", 8'h58);
    write_force(16'h0200);

    phase = "R5";
    write_mode(16'h0F00);
    expect_out("R5 select idle high", 8'h5F);
    frame_active = 1'b1;
    step();
    expect_out("R5 select active low, R8 upper kept", 8'h50);
    frame_active = 1'b0;
    step();
    expect_out("R5 select released", 8'h5F);

    phase = "R6";
    write_mode(16'h0F0F);
    expect_out("R6 inverted idle select", 8'h50);
    frame_active = 1'b1;
    step();
    expect_out("R6 inverted active select", 8'h5F);
    frame_active = 1'b0;
    write_mode(16'h00F0);
    expect_out("R6 invert forced lines", 8'hAA);

    phase = "R7";
    write_mode(16'h0F00);
    frame_active = 1'b1;
    write_force(16'h0010);
    expect_out("R7 select active, line4 forced low", 8'h40);
    frame_active = 1'b0;
    write_mode(16'h0000);
    expect_out("R7 forced levels return", 8'h4A);

    phase = "R9";
    write_mode(16'h8000);
    frame_active = 1'b1;
    expect_out("R9 frame not yet seen", 8'hCA);
    step();
    expect_out("R9 frame seen first edge", 8'h4A);
    frame_active = 1'b0;
    step();

    phase = "R1";
    rst_n = 1'b0;
    step();
    expect_out("R1 reset again", 8'hFF);
    rst_n = 1'b1;
    step();
    frame_active = 1'b1;
    step();
    expect_out("R1 select off after reset", 8'hFF);
    frame_active = 1'b0;
    step();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule